// File: doc/BRIEF.md
# Fixed-Format Serial Port with Double-Buffered Transmit

This block is a full-duplex asynchronous serial port with a frame layout that cannot be changed. Every character on the wire has one low start bit, eight data bits sent least significant bit first, one parity bit that makes the total count of ones odd, and one high stop bit. That is eleven bit times per character. The whole block runs from a dedicated timer clock. With the default division of 1250 clocks per bit and a 12 MHz timer clock, the line rate is 9600 baud.

The host writes a 16-bit word to the transmit side, and only its low byte is sent. A one-byte holding stage sits in front of the shift stage, so a second byte written while a character is on the line follows it with no idle time between them. On the receive side, the host gets the most recent character as a zero-extended 16-bit word. A status word reports data-ready, the three receive error kinds, an OR of those errors, and separate empty flags for the holding stage and the shift stage. Reading the receive word clears data-ready. Reading the status word clears the error flags.

Top module: `sfu_uart`

## Requirements
- R1: After reset the serial output is high, the receive word is 0 and the status word is 0x0006 (bit 2 holding-empty and bit 1 line-empty set, all else 0). The serial output is high whenever bit 1 is set.
- R2: A transmitted character is a low start bit, data bits 0 to 7 in that order, a parity bit equal to the inverted XOR of the data bits, and a high stop bit. Each bit lasts BIT_CYCLES clock cycles.
- R3: A write strobe with bit 1 set captures wr_data[7:0] and clears bit 1 on the next cycle. The byte moves into the shift stage one cycle later, where the start bit begins and bit 2 returns high. wr_data[15:8] is ignored.
- R4: A byte written while a character is being shifted clears bit 2 until it is taken. Its start bit follows the previous stop bit with no idle cycle in between.
- R5: Bit 1 stays low until the stop bit of the last queued character has ended, and then goes high.
- R6: A received character sets status bit 0 and places the byte in rx_word[7:0], with rx_word[15:8] zero. A receive-read strobe clears bit 0.
- R7: If a character completes while bit 0 is still set and no receive read occurs in that cycle, status bit 6 (overrun) is set and rx_word holds the newer byte.
- R8: A low line at the stop-bit sample sets status bit 5 (framing). The receiver then waits for the line to go high before it looks for a new start bit.
- R9: A received character whose data and parity bits hold an even number of ones sets status bit 4 (parity).
- R10: Status bit 7 equals the OR of bits 6, 5 and 4. A status-read strobe clears bits 6 to 4 on the following cycle.
- R11: A low pulse on the serial input that is gone by the half-bit confirmation point starts no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock that drives all logic |
| rst | input | 1 | Synchronous reset, active high |
| wr_tx | input | 1 | Transmit write strobe |
| wr_data | input | 16 | Word written to transmit; low byte is sent |
| rd_rx | input | 1 | Receive read strobe; clears data-ready |
| rd_stat | input | 1 | Status read strobe; clears error flags |
| rx_word | output | 16 | Last received byte, zero-extended |
| stat_word | output | 16 | Status flags (bits 7,6,5,4,2,1,0) |
| ser_in | input | 1 | Serial receive line |
| ser_out | output | 1 | Serial transmit line, idles high |

## Verification
The bench builds the block with BIT_CYCLES set to 16 instead of 1250. A full character then takes 176 cycles, so both back-to-back transmit frames and several received characters fit in a short run. At this setting the half-bit confirmation point is eight cycles after the start edge. That is long enough to inject a short glitch that must be rejected, while real start bits still pass. The same setting also lets the bench place the exact stop-to-start boundary of consecutive transmit frames, and the overrun, parity and framing cases, within a few hundred cycles of one another.

// File: rtl/sfu_uart_pkg.sv
package sfu_uart_pkg;

    localparam int FRAME_BITS = 11;
    localparam int DATA_BITS  = 8;

    localparam int ST_READY = 0;
    localparam int ST_LINE  = 1;
    localparam int ST_HOLD  = 2;
    localparam int ST_PAR   = 4;
    localparam int ST_FRM   = 5;
    localparam int ST_OVR   = 6;
    localparam int ST_ERR   = 7;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_WAIT_HIGH
    } rx_state_e;

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 par_err;
        logic                 frm_err;
    } rx_result_t;

    function automatic logic odd_parity(input logic [DATA_BITS-1:0] d);
        return ~(^d);
    endfunction

endpackage

// File: rtl/sfu_uart_tx.sv
module sfu_uart_tx
    import sfu_uart_pkg::*;
#(
    parameter int BIT_CYCLES = 1250
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [DATA_BITS-1:0] wr_byte,
    output logic                 ser_out,
    output logic                 hold_empty,
    output logic                 line_empty
);
    localparam int CW = $clog2(BIT_CYCLES);
    localparam int IW = $clog2(FRAME_BITS);

    logic [DATA_BITS-1:0]  hold_q;
    logic                  hold_full_q;
    logic                  busy_q;
    logic [FRAME_BITS-1:0] shift_q;
    logic [CW-1:0]         cnt_q;
    logic [IW-1:0]         idx_q;

    logic bit_end, frame_end, take;

    assign bit_end   = busy_q && (cnt_q == CW'(BIT_CYCLES - 1));
    assign frame_end = bit_end && (idx_q == IW'(FRAME_BITS - 1));
    assign take      = hold_full_q && (!busy_q || frame_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
            busy_q      <= 1'b0;
            shift_q     <= '1;
            cnt_q       <= '0;
            idx_q       <= '0;
        end else begin
            if (take) hold_full_q <= 1'b0;
            if (wr_en) begin
                hold_q      <= wr_byte;
                hold_full_q <= 1'b1;
            end
            if (take) begin
                shift_q <= {1'b1, odd_parity(hold_q), hold_q, 1'b0};
                busy_q  <= 1'b1;
                cnt_q   <= '0;
                idx_q   <= '0;
            end else if (busy_q) begin
                if (bit_end) begin
                    cnt_q   <= '0;
                    shift_q <= {1'b1, shift_q[FRAME_BITS-1:1]};
                    idx_q   <= idx_q + 1'b1;
                    if (frame_end) busy_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign ser_out    = busy_q ? shift_q[0] : 1'b1;
    assign hold_empty = !hold_full_q;
    assign line_empty = !busy_q && !hold_full_q;

endmodule

// File: rtl/sfu_uart_rx.sv
module sfu_uart_rx
    import sfu_uart_pkg::*;
#(
    parameter int BIT_CYCLES = 1250
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ser_in,
    output logic       done,
    output rx_result_t result
);
    localparam int CW   = $clog2(BIT_CYCLES);
    localparam int HALF = BIT_CYCLES / 2;

    logic                 sync1_q, line_q;
    rx_state_e            state_q;
    logic [CW-1:0]        cnt_q;
    logic [2:0]           idx_q;
    logic [DATA_BITS-1:0] data_q;
    logic                 par_q;
    logic                 done_q;
    rx_result_t           res_q;

    logic full_end, half_end;
    assign full_end = (cnt_q == CW'(BIT_CYCLES - 1));
    assign half_end = (cnt_q == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b1;
            line_q  <= 1'b1;
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            data_q  <= '0;
            par_q   <= 1'b0;
            done_q  <= 1'b0;
            res_q   <= '0;
        end else begin
            sync1_q <= ser_in;
            line_q  <= sync1_q;
            done_q  <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                    if (!line_q) state_q <= RX_START;
                end
                RX_START: begin
                    if (half_end) begin
                        cnt_q   <= '0;
                        idx_q   <= '0;
                        state_q <= line_q ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (full_end) begin
                        cnt_q  <= '0;
                        data_q <= {line_q, data_q[DATA_BITS-1:1]};
                        idx_q  <= idx_q + 1'b1;
                        if (idx_q == 3'd7) state_q <= RX_PARITY;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_PARITY: begin
                    if (full_end) begin
                        cnt_q   <= '0;
                        par_q   <= line_q;
                        state_q <= RX_STOP;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (full_end) begin
                        cnt_q         <= '0;
                        done_q        <= 1'b1;
                        res_q.data    <= data_q;
                        res_q.par_err <= !(^{data_q, par_q});
                        res_q.frm_err <= !line_q;
                        state_q       <= line_q ? RX_IDLE : RX_WAIT_HIGH;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_WAIT_HIGH: begin
                    if (line_q) state_q <= RX_IDLE;
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    assign done   = done_q;
    assign result = res_q;

endmodule

// File: rtl/sfu_uart_stat.sv
module sfu_uart_stat
    import sfu_uart_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_done,
    input  rx_result_t  rx_res,
    input  logic        rd_rx,
    input  logic        rd_stat,
    input  logic        hold_empty,
    input  logic        line_empty,
    output logic [15:0] rx_word,
    output logic [15:0] stat_word
);
    logic [DATA_BITS-1:0] buf_q;
    logic ready_q, ovr_q, frm_q, par_q;
    logic ovr_keep, frm_keep, par_keep;

    assign ovr_keep = ovr_q && !rd_stat;
    assign frm_keep = frm_q && !rd_stat;
    assign par_keep = par_q && !rd_stat;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q   <= '0;
            ready_q <= 1'b0;
            ovr_q   <= 1'b0;
            frm_q   <= 1'b0;
            par_q   <= 1'b0;
        end else if (rx_done) begin
            buf_q   <= rx_res.data;
            ready_q <= 1'b1;
            ovr_q   <= ovr_keep || (ready_q && !rd_rx);
            frm_q   <= frm_keep || rx_res.frm_err;
            par_q   <= par_keep || rx_res.par_err;
        end else begin
            if (rd_rx) ready_q <= 1'b0;
            ovr_q <= ovr_keep;
            frm_q <= frm_keep;
            par_q <= par_keep;
        end
    end

    always_comb begin
        stat_word          = '0;
        stat_word[ST_READY] = ready_q;
        stat_word[ST_LINE]  = line_empty;
        stat_word[ST_HOLD]  = hold_empty;
        stat_word[ST_PAR]   = par_q;
        stat_word[ST_FRM]   = frm_q;
        stat_word[ST_OVR]   = ovr_q;
        stat_word[ST_ERR]   = ovr_q | frm_q | par_q;
    end

    assign rx_word = {8'h00, buf_q};

endmodule

// File: rtl/sfu_uart.sv
module sfu_uart
    import sfu_uart_pkg::*;
#(
    parameter int BIT_CYCLES = 1250
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_tx,
    input  logic [15:0] wr_data,
    input  logic        rd_rx,
    input  logic        rd_stat,
    output logic [15:0] rx_word,
    output logic [15:0] stat_word,
    input  logic        ser_in,
    output logic        ser_out
);
    logic       hold_empty, line_empty;
    logic       rx_done;
    rx_result_t rx_res;

    sfu_uart_tx #(.BIT_CYCLES(BIT_CYCLES)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_tx),
        .wr_byte    (wr_data[DATA_BITS-1:0]),
        .ser_out    (ser_out),
        .hold_empty (hold_empty),
        .line_empty (line_empty)
    );

    sfu_uart_rx #(.BIT_CYCLES(BIT_CYCLES)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .ser_in (ser_in),
        .done   (rx_done),
        .result (rx_res)
    );

    sfu_uart_stat u_stat (
        .clk        (clk),
        .rst        (rst),
        .rx_done    (rx_done),
        .rx_res     (rx_res),
        .rd_rx      (rd_rx),
        .rd_stat    (rd_stat),
        .hold_empty (hold_empty),
        .line_empty (line_empty),
        .rx_word    (rx_word),
        .stat_word  (stat_word)
    );

endmodule

// File: rtl/sfu_uart_chk.sv
module sfu_uart_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_tx,
    input logic        rd_rx,
    input logic        rd_stat,
    input logic        rx_done,
    input logic [15:0] stat_word,
    input logic        ser_out
);
    a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
        stat_word[1] |-> ser_out);

    a_r3_write_takes: assert property (@(posedge clk) disable iff (rst)
        (wr_tx && stat_word[1]) |=> !stat_word[1]);

    a_r6_done_sets_ready: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> stat_word[0]);

    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_rx && !rx_done) |=> !stat_word[0]);

    a_r7_overrun: assert property (@(posedge clk) disable iff (rst)
        (rx_done && stat_word[0] && !rd_rx) |=> stat_word[6]);

    a_r10_stat_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !rx_done) |=> (stat_word[7:4] == 4'h0));
endmodule

bind sfu_uart sfu_uart_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_tx     (wr_tx),
    .rd_rx     (rd_rx),
    .rd_stat   (rd_stat),
    .rx_done   (rx_done),
    .stat_word (stat_word),
    .ser_out   (ser_out)
);

// File: tb/tb_sfu_uart.sv
module tb_sfu_uart;
    localparam int CLK_PERIOD = 10;
    localparam int BIT = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_tx = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_rx = 1'b0;
    logic        rd_stat = 1'b0;
    logic        ser_in = 1'b1;
    logic [15:0] rx_word, stat_word;
    logic        ser_out;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfu_uart #(.BIT_CYCLES(BIT)) dut (
        .clk(clk), .rst(rst), .wr_tx(wr_tx), .wr_data(wr_data),
        .rd_rx(rd_rx), .rd_stat(rd_stat), .rx_word(rx_word),
        .stat_word(stat_word), .ser_in(ser_in), .ser_out(ser_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] frame_of(input logic [7:0] d);
        return {1'b1, ~(^d), d, 1'b0};
    endfunction

    task automatic capture(input bit find_edge, output logic [10:0] f);
        if (find_edge) begin
            while (ser_out !== 1'b0) @(negedge clk);
            repeat (BIT/2) @(negedge clk);
        end else begin
            repeat (BIT) @(negedge clk);
        end
        f[0] = ser_out;
        for (int i = 1; i < 11; i++) begin
            repeat (BIT) @(negedge clk);
            f[i] = ser_out;
        end
    endtask

    task automatic write_tx(input logic [15:0] w);
        @(negedge clk); wr_tx = 1'b1; wr_data = w;
        @(negedge clk); wr_tx = 1'b0;
    endtask

    task automatic pulse_rd_rx();
        @(negedge clk); rd_rx = 1'b1;
        @(negedge clk); rd_rx = 1'b0;
    endtask

    task automatic pulse_rd_stat();
        @(negedge clk); rd_stat = 1'b1;
        @(negedge clk); rd_stat = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic stop_v);
        logic [10:0] bits;
        bits = {stop_v, (~(^d)) ^ bad_par, d, 1'b0};
        @(negedge clk);
        for (int i = 0; i < 11; i++) begin
            ser_in = bits[i];
            repeat (BIT) @(negedge clk);
        end
        ser_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 status after reset", stat_word, 16'h0006);
        check("R1 serial idle high", {15'h0, ser_out}, 16'h0001);
        check("R1 rx word after reset", rx_word, 16'h0000);
    endtask

    task automatic t_tx_single();
        logic [10:0] f;
        write_tx(16'h3CA5);
        check("R3 line-empty drops after write", {15'h0, stat_word[1]}, 16'h0);
        check("R3 holding full before transfer", {15'h0, stat_word[2]}, 16'h0);
        @(negedge clk);
        check("R3 holding empty after transfer", {15'h0, stat_word[2]}, 16'h1);
        check("R3 start bit begun", {15'h0, ser_out}, 16'h0);
        capture(1'b1, f);
        check("R2 frame bits of 0xA5", {5'h0, f}, {5'h0, frame_of(8'hA5)});
        check("R5 line-empty low during stop bit", {15'h0, stat_word[1]}, 16'h0);
        repeat (BIT/2 + 2) @(negedge clk);
        check("R5 line-empty high after stop", {15'h0, stat_word[1]}, 16'h1);
        check("R1 idle high after frame", {15'h0, ser_out}, 16'h1);
    endtask

    task automatic t_tx_b2b();
        logic [10:0] f1, f2;
        write_tx(16'h0001);
        repeat (3) @(negedge clk);
        write_tx(16'hFFFE);
        check("R4 holding full while shifting", {15'h0, stat_word[2]}, 16'h0);
        capture(1'b1, f1);
        check("R2 first frame 0x01", {5'h0, f1}, {5'h0, frame_of(8'h01)});
        check("R5 line-empty low with queued byte", {15'h0, stat_word[1]}, 16'h0);
        capture(1'b0, f2);
        check("R4 second frame follows with no gap", {5'h0, f2}, {5'h0, frame_of(8'hFE)});
        repeat (BIT/2 + 2) @(negedge clk);
        check("R5 empty after queue drains", {15'h0, stat_word[1]}, 16'h1);
    endtask

    task automatic t_rx_good();
        send_frame(8'h5A, 1'b0, 1'b1);
        check("R6 data ready", {15'h0, stat_word[0]}, 16'h1);
        check("R6 rx word zero-extended", rx_word, 16'h005A);
        check("R10 no error bits", {12'h0, stat_word[7:4]}, 16'h0);
        pulse_rd_rx();
        check("R6 read clears data ready", {15'h0, stat_word[0]}, 16'h0);
    endtask

    task automatic t_rx_overrun();
        send_frame(8'h11, 1'b0, 1'b1);
        send_frame(8'h22, 1'b0, 1'b1);
        check("R7 overrun bit 6", {15'h0, stat_word[6]}, 16'h1);
        check("R10 error OR bit 7 on overrun", {15'h0, stat_word[7]}, 16'h1);
        check("R7 newest byte kept", rx_word, 16'h0022);
        pulse_rd_stat();
        check("R10 status read clears errors", {12'h0, stat_word[7:4]}, 16'h0);
        pulse_rd_rx();
    endtask

    task automatic t_rx_parity();
        send_frame(8'h37, 1'b1, 1'b1);
        check("R9 parity error bit 4", {12'h0, stat_word[7:4]}, 16'h9);
        pulse_rd_stat();
        pulse_rd_rx();
        check("R10 parity cleared", {12'h0, stat_word[7:4]}, 16'h0);
    endtask

    task automatic t_rx_framing();
        send_frame(8'hC3, 1'b0, 1'b0);
        check("R8 framing error bit 5", {12'h0, stat_word[7:4]}, 16'hA);
        pulse_rd_stat();
        pulse_rd_rx();
        send_frame(8'h3C, 1'b0, 1'b1);
        check("R8 receiver rearmed after line high", rx_word, 16'h003C);
        check("R8 clean frame no errors", {12'h0, stat_word[7:4]}, 16'h0);
        pulse_rd_rx();
    endtask

    task automatic t_false_start();
        @(negedge clk); ser_in = 1'b0;
        repeat (3) @(negedge clk);
        ser_in = 1'b1;
        repeat (12*BIT) @(negedge clk);
        check("R11 glitch gives no data", {15'h0, stat_word[0]}, 16'h0);
        check("R11 glitch gives no errors", {12'h0, stat_word[7:4]}, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_tx_single();
        t_tx_b2b();
        t_rx_good();
        t_rx_overrun();
        t_rx_parity();
        t_rx_framing();
        t_false_start();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule